// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block takes a 32-bit processor core out of reset. A reset request arrives on one of two inputs, one for a power-on reset and one for a manual reset. The block then reads two words from a fixed vector table over a simple request/acknowledge read port. The first word is the initial program counter and the second is the initial stack pointer. Each reset kind has its own pair of table slots.

After both words are captured, the block loads the starting values of the core's control state: the vector base, the four-bit interrupt mask in the status word, the two bank status flags and the register-bank pointer. It then raises a one-cycle start strobe, and the fetched program counter is valid on its output in that cycle. The core begins execution at that address.

A new reset request at any point, including after the start strobe, parks the control outputs and runs the sequence again from the first read.

Top module: `rvf_boot_seq`

## Requirements
- R1: After a power-on request, the first read uses address 0x00000000 (program counter) and the second uses 0x00000004 (stack pointer).
- R2: After a manual request without a power-on request, the reads use address 0x00000008 and then 0x0000000C.
- R3: When both requests are high in the same cycle, the power-on kind wins: the reads use the power-on slots and `boot_is_manual` reads 0.
- R4: A read is offered by holding `rd_valid` high. It completes in the first cycle in which `rd_ack` is also high, and `rd_data` is taken in that cycle. While waiting, `rd_addr` stays unchanged, and the sequence advances only on completion.
- R5: In any cycle with a reset request, `rd_valid` and `core_start` are low. The sequence restarts, and the next read issued is the program-counter read for the new kind.
- R6: A reset request sets the control outputs to a parked pattern: `vbr` all ones, `sr_imask` 0, `sr_bo` 1, `sr_cs` 1, `bank_ptr` all ones. The reset pattern of the block's own `rst_n` is the same. After the stack-pointer read completes, the next cycle loads `vbr` = 0, `sr_imask` = 0xF, `sr_bo` = 0, `sr_cs` = 0 and `bank_ptr` = 0.
- R7: `core_start` is high for exactly one cycle per completed sequence. That cycle is the second one after the cycle in which the stack-pointer read completes.
- R8: `boot_pc` holds the word returned by the program-counter read and `boot_sp` the word returned by the stack-pointer read. Both are valid while `core_start` is high.
- R9: After `core_start`, no read is issued until the next reset request.
- R10: `boot_is_manual` is 1 from the cycle after a manual-only request, and 0 from the cycle after a request that includes power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| por_req | input | 1 | Power-on reset request |
| man_req | input | 1 | Manual reset request |
| rd_valid | output | 1 | Read request offered |
| rd_addr | output | ADDR_W | Byte address of the offered read |
| rd_ack | input | 1 | Read accepted; data present this cycle |
| rd_data | input | XLEN | Read data |
| core_start | output | 1 | One-cycle release strobe for the core |
| boot_pc | output | XLEN | Fetched initial program counter |
| boot_sp | output | XLEN | Fetched initial stack pointer |
| boot_is_manual | output | 1 | Kind of the latest reset request (1 = manual) |
| vbr | output | XLEN | Vector base value |
| sr_imask | output | IMASK_W | Interrupt mask field of the status word |
| sr_bo | output | 1 | Bank-overflow status flag |
| sr_cs | output | 1 | CS status flag |
| bank_ptr | output | BANK_W | Register-bank pointer |

## Verification
The sequence runs from a power-on request, from a manual request and from both requests together. The resulting addresses and the `boot_is_manual` value tell the two vector pairs and the priority rule apart. The memory model answers with no wait, with short waits and with long waits, which shows that each read is held until acknowledged and that the data is captured in the right cycle. Restart requests are placed during the stack-pointer read and after the start strobe. These runs separate a true restart from the first read, with one start strobe per completed run, from a sequence that resumes where it stopped or releases the core twice.

// File: rtl/rvf_pkg.sv
package rvf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_FETCH_PC = 3'd1,
      ST_FETCH_SP = 3'd2,
      ST_INIT     = 3'd3,
      ST_LAUNCH   = 3'd4,
      ST_RUN      = 3'd5
   } seq_state_e;

   typedef enum logic {
      KIND_POWER_ON = 1'b0,
      KIND_MANUAL   = 1'b1
   } boot_kind_e;

   localparam int unsigned SLOT_PC   = 0;
   localparam int unsigned SLOT_SP   = 1;
   localparam int unsigned NUM_SLOTS = 2;

endpackage

// File: rtl/rvf_req_arb.sv
module rvf_req_arb
   import rvf_pkg::*;
(
   input  logic       por_req,
   input  logic       man_req,
   output logic       restart,
   output boot_kind_e kind
);

   // Power-on outranks manual when both arrive together.
   always_comb begin
      restart = por_req | man_req;
      kind    = por_req ? KIND_POWER_ON : KIND_MANUAL;
   end

endmodule

// File: rtl/rvf_seq_fsm.sv
module rvf_seq_fsm
   import rvf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic rd_ack,
   output logic rd_valid,
   output logic slot_sp,
   output logic capture,
   output logic ctrl_park,
   output logic ctrl_load,
   output logic core_start
);

   seq_state_e st_q, st_d;
   logic       fetching;

   always_comb begin
      fetching   = (st_q == ST_FETCH_PC) || (st_q == ST_FETCH_SP);
      rd_valid   = fetching && !restart;
      slot_sp    = (st_q == ST_FETCH_SP);
      capture    = rd_valid && rd_ack;
      ctrl_park  = restart;
      ctrl_load  = (st_q == ST_INIT) && !restart;
      core_start = (st_q == ST_LAUNCH) && !restart;
   end

   always_comb begin
      st_d = st_q;
      if (restart) begin
         st_d = ST_FETCH_PC;
      end else begin
         unique case (st_q)
            ST_IDLE:     st_d = ST_IDLE;
            ST_FETCH_PC: if (rd_ack) st_d = ST_FETCH_SP;
            ST_FETCH_SP: if (rd_ack) st_d = ST_INIT;
            ST_INIT:     st_d = ST_LAUNCH;
            ST_LAUNCH:   st_d = ST_RUN;
            ST_RUN:      st_d = ST_RUN;
            default:     st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   // R5: a request is followed by the program-counter read unless repeated
   p_restart_refetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (restart || (rd_valid && !slot_sp)));

   // R7: start strobe lasts one cycle
   p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> !core_start);

   // R9: no read after the core is released
   p_quiet_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> !rd_valid);

endmodule

// File: rtl/rvf_ctrl_init.sv
module rvf_ctrl_init #(
   parameter int unsigned VBR_W   = 32,
   parameter int unsigned IMASK_W = 4,
   parameter int unsigned BANK_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               park,
   input  logic               load,
   output logic [VBR_W-1:0]   vbr,
   output logic [IMASK_W-1:0] sr_imask,
   output logic               sr_bo,
   output logic               sr_cs,
   output logic [BANK_W-1:0]  bank_ptr
);

   localparam logic [VBR_W-1:0]   VBR_PARK   = '1;
   localparam logic [IMASK_W-1:0] IMASK_PARK = '0;
   localparam logic [BANK_W-1:0]  BANK_PARK  = '1;
   localparam logic [VBR_W-1:0]   VBR_INIT   = '0;
   localparam logic [IMASK_W-1:0] IMASK_INIT = '1;
   localparam logic [BANK_W-1:0]  BANK_INIT  = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vbr      <= VBR_PARK;
         sr_imask <= IMASK_PARK;
         sr_bo    <= 1'b1;
         sr_cs    <= 1'b1;
         bank_ptr <= BANK_PARK;
      end else if (park) begin
         vbr      <= VBR_PARK;
         sr_imask <= IMASK_PARK;
         sr_bo    <= 1'b1;
         sr_cs    <= 1'b1;
         bank_ptr <= BANK_PARK;
      end else if (load) begin
         vbr      <= VBR_INIT;
         sr_imask <= IMASK_INIT;
         sr_bo    <= 1'b0;
         sr_cs    <= 1'b0;
         bank_ptr <= BANK_INIT;
      end
   end

   // R6: a request leaves the flags parked in the next cycle
   p_park_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      park |=> (sr_bo && sr_cs && (sr_imask == IMASK_PARK)));

endmodule

// File: rtl/rvf_boot_seq.sv
module rvf_boot_seq
   import rvf_pkg::*;
#(
   parameter int unsigned          XLEN         = 32,
   parameter int unsigned          ADDR_W       = 32,
   parameter int unsigned          IMASK_W      = 4,
   parameter int unsigned          BANK_W       = 4,
   parameter logic [ADDR_W-1:0]    POR_VEC_BASE = 'h0,
   parameter logic [ADDR_W-1:0]    MAN_VEC_BASE = 'h8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               por_req,
   input  logic               man_req,
   output logic               rd_valid,
   output logic [ADDR_W-1:0]  rd_addr,
   input  logic               rd_ack,
   input  logic [XLEN-1:0]    rd_data,
   output logic               core_start,
   output logic [XLEN-1:0]    boot_pc,
   output logic [XLEN-1:0]    boot_sp,
   output logic               boot_is_manual,
   output logic [XLEN-1:0]    vbr,
   output logic [IMASK_W-1:0] sr_imask,
   output logic               sr_bo,
   output logic               sr_cs,
   output logic [BANK_W-1:0]  bank_ptr
);

   localparam int unsigned       WORD_BYTES = XLEN / 8;
   localparam logic [ADDR_W-1:0] SP_OFFSET  = ADDR_W'(WORD_BYTES);

   initial begin
      assert (XLEN % 8 == 0 && XLEN >= 16)
         else $error("XLEN must be a whole number of bytes, at least 16");
      assert (ADDR_W >= 4)
         else $error("ADDR_W too small for the vector table");
      assert (IMASK_W >= 1 && BANK_W >= 1)
         else $error("field widths must be nonzero");
      assert (POR_VEC_BASE % WORD_BYTES == 0 && MAN_VEC_BASE % WORD_BYTES == 0)
         else $error("vector bases must be word aligned");
   end

   logic       restart;
   boot_kind_e req_kind;
   boot_kind_e kind_q;
   logic       slot_sp;
   logic       capture;
   logic       ctrl_park;
   logic       ctrl_load;
   logic [XLEN-1:0] vec_q [NUM_SLOTS];

   rvf_req_arb u_arb (
      .por_req (por_req),
      .man_req (man_req),
      .restart (restart),
      .kind    (req_kind)
   );

   rvf_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .rd_ack     (rd_ack),
      .rd_valid   (rd_valid),
      .slot_sp    (slot_sp),
      .capture    (capture),
      .ctrl_park  (ctrl_park),
      .ctrl_load  (ctrl_load),
      .core_start (core_start)
   );

   rvf_ctrl_init #(
      .VBR_W   (XLEN),
      .IMASK_W (IMASK_W),
      .BANK_W  (BANK_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .park     (ctrl_park),
      .load     (ctrl_load),
      .vbr      (vbr),
      .sr_imask (sr_imask),
      .sr_bo    (sr_bo),
      .sr_cs    (sr_cs),
      .bank_ptr (bank_ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       kind_q <= KIND_POWER_ON;
      else if (restart) kind_q <= req_kind;
   end

   always_comb begin
      rd_addr = ((kind_q == KIND_MANUAL) ? MAN_VEC_BASE : POR_VEC_BASE)
              + (slot_sp ? SP_OFFSET : '0);
   end

   // One capture register per vector-table slot.
   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            vec_q[g] <= '0;
         else if (capture && (slot_sp == (g == SLOT_SP)))
            vec_q[g] <= rd_data;
      end
   end

   assign boot_pc        = vec_q[SLOT_PC];
   assign boot_sp        = vec_q[SLOT_SP];
   assign boot_is_manual = (kind_q == KIND_MANUAL);

   // R1: first read after a power-on request uses the power-on PC slot
   p_por_pc_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(por_req)) |-> (rd_addr == POR_VEC_BASE));

   // R2: first read after a manual-only request uses the manual PC slot
   p_man_pc_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(man_req && !por_req)) |-> (rd_addr == MAN_VEC_BASE));

   // R3: power-on wins when both requests coincide
   p_por_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
      por_req |=> !boot_is_manual);

   // R4: an unanswered read stays offered at the same address
   p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ack) |=> (por_req || man_req || (rd_valid && $stable(rd_addr))));

   // R6: control state is initialised by the time the core is released
   p_start_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |-> (vbr == '0 && sr_imask == '1 && !sr_bo && !sr_cs && bank_ptr == '0));

endmodule

// File: tb/rvf_boot_seq_test.sv
module rvf_boot_seq_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        por_req = 1'b0;
   logic        man_req = 1'b0;
   logic        rd_valid;
   logic [31:0] rd_addr;
   logic        rd_ack = 1'b0;
   logic [31:0] rd_data = '0;
   logic        core_start;
   logic [31:0] boot_pc, boot_sp, vbr;
   logic        boot_is_manual;
   logic [3:0]  sr_imask, bank_ptr;
   logic        sr_bo, sr_cs;

   always #(CLK_PERIOD/2) clk = ~clk;

   rvf_boot_seq uut (
      .clk(clk), .rst_n(rst_n), .por_req(por_req), .man_req(man_req),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .core_start(core_start), .boot_pc(boot_pc), .boot_sp(boot_sp),
      .boot_is_manual(boot_is_manual), .vbr(vbr), .sr_imask(sr_imask),
      .sr_bo(sr_bo), .sr_cs(sr_cs), .bank_ptr(bank_ptr)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference model state
   int          m_st = 0;   // 0 idle,1 pc read,2 sp read,3 init,4 launch,5 running
   bit          m_man = 0;
   logic [31:0] m_pc = '0, m_sp = '0, m_vbr = 32'hFFFF_FFFF;
   logic [3:0]  m_mask = 4'h0, m_bn = 4'hF;
   bit          m_bo = 1, m_cs = 1;
   int          m_starts = 0;
   int          lat = 0, wait_cnt = 0;
   logic [31:0] seed = 32'h1234_0000;

   function automatic logic [31:0] mem_word(logic [31:0] a);
      return seed ^ (a * 32'h0001_0101) ^ 32'h5A00_00C3;
   endfunction

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic cycle(bit por, bit man);
      bit          req, exp_rv, exp_start;
      logic [31:0] exp_addr;
      @(negedge clk);
      por_req = por;
      man_req = man;
      #1;
      if (rd_valid && wait_cnt >= lat) begin
         rd_ack  = 1'b1;
         rd_data = mem_word(rd_addr);
      end else begin
         rd_ack  = 1'b0;
         rd_data = 32'hDEAD_BEEF;
      end
      #1;
      req       = por || man;
      exp_rv    = (m_st == 1 || m_st == 2) && !req;
      exp_addr  = (m_man ? 32'h8 : 32'h0) + ((m_st == 2) ? 32'h4 : 32'h0);
      exp_start = (m_st == 4) && !req;
      check(rd_valid == exp_rv, "R4/R5/R9 rd_valid", 64'(rd_valid), 64'(exp_rv));
      if (exp_rv) check(rd_addr == exp_addr, "R1/R2 rd_addr", 64'(rd_addr), 64'(exp_addr));
      check(core_start == exp_start, "R7 core_start", 64'(core_start), 64'(exp_start));
      check(boot_pc == m_pc && boot_sp == m_sp, "R8 boot_pc/sp",
            {boot_pc, boot_sp}, {m_pc, m_sp});
      check(vbr == m_vbr && sr_imask == m_mask && sr_bo == m_bo && sr_cs == m_cs && bank_ptr == m_bn,
            "R6 control", {vbr, sr_imask, bank_ptr, 6'(sr_bo), 2'(sr_cs)},
            {m_vbr, m_mask, m_bn, 6'(m_bo), 2'(m_cs)});
      check(boot_is_manual == m_man, "R3/R10 kind", 64'(boot_is_manual), 64'(m_man));
      @(posedge clk);
      if (req) begin
         m_st = 1; m_man = !por; wait_cnt = 0; m_starts = 0;
         m_vbr = 32'hFFFF_FFFF; m_mask = 4'h0; m_bo = 1; m_cs = 1; m_bn = 4'hF;
      end else begin
         case (m_st)
            1, 2: begin
               if (rd_ack) begin
                  if (m_st == 1) m_pc = mem_word(exp_addr);
                  else           m_sp = mem_word(exp_addr);
                  m_st = m_st + 1;
                  wait_cnt = 0;
               end else begin
                  wait_cnt++;
               end
            end
            3: begin
               m_vbr = '0; m_mask = 4'hF; m_bo = 0; m_cs = 0; m_bn = 4'h0;
               m_st = 4;
            end
            4: begin m_starts++; m_st = 5; end
            default: ;
         endcase
      end
   endtask

   task automatic finish_checks(string what);
      check(m_starts == 1, {"R7 one start ", what}, 64'(m_starts), 64'd1);
      check(m_st == 5 && !rd_valid, {"R9 quiet after start ", what}, 64'(rd_valid), 64'd0);
      check(boot_pc == mem_word(m_man ? 32'h8 : 32'h0), {"R8 pc value ", what},
            64'(boot_pc), 64'(mem_word(m_man ? 32'h8 : 32'h0)));
      check(boot_sp == mem_word(m_man ? 32'hC : 32'h4), {"R8 sp value ", what},
            64'(boot_sp), 64'(mem_word(m_man ? 32'hC : 32'h4)));
   endtask

   task automatic run_boot(bit por, bit man, int latency, string what);
      lat = latency;
      seed = seed + 32'h0011_2233;
      cycle(por, man);
      repeat (4 * latency + 10) cycle(0, 0);
      finish_checks(what);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         report();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state: parked control, nothing offered (R6, R9)
      cycle(0, 0);
      cycle(0, 0);
      check(vbr == 32'hFFFF_FFFF && sr_imask == 4'h0 && bank_ptr == 4'hF,
            "R6 parked after rst_n", {vbr, sr_imask, bank_ptr}, {32'hFFFF_FFFF, 4'h0, 4'hF});

      run_boot(1, 0, 0, "por lat0");          // R1
      check(!boot_is_manual, "R10 por kind", 64'(boot_is_manual), 64'd0);
      run_boot(0, 1, 3, "man lat3");          // R2
      check(boot_is_manual, "R10 man kind", 64'(boot_is_manual), 64'd1);
      run_boot(1, 1, 1, "both lat1");         // R3
      check(!boot_is_manual, "R3 both -> power-on", 64'(boot_is_manual), 64'd0);
      run_boot(1, 0, 6, "por lat6");          // R4 long waits

      // R5: restart during the stack-pointer read
      lat = 2;
      seed = seed + 32'h0101_0101;
      cycle(1, 0);
      repeat (4) cycle(0, 0);
      check(m_st == 2, "R5 in sp read before restart", 64'(m_st), 64'd2);
      cycle(0, 1);
      repeat (20) cycle(0, 0);
      finish_checks("restart mid-sp");

      // R5: restart after the core is running
      lat = 1;
      cycle(0, 1);
      repeat (12) cycle(0, 0);
      finish_checks("restart after run");

      done = 1;
      report();
      $finish;
   end

endmodule